// File: doc/BRIEF.md
# Channel Status and User Bit Demultiplexer

This block sits behind a biphase decoder in an S/PDIF receiver. For every decoded subframe it takes a one-cycle strobe with the subframe's channel-status bit and user bit. The strobe also says whether the subframe is left or right, and whether it opened a block, which happens on the left subframe of frame 0. The block re-times both bits onto serial outputs in arrival order (left 0, right 0, left 1, right 1, up to left 191, right 191). A channel indicator travels with them, so the downstream serial interface can align them to its word clock.

The block counts frames from the block-start marker. It drives a block-start pulse that stays high for the first 32 frames of each 192-frame status block. It also gathers the first eight channel-status bits of the left channel, which form status byte 0, and decodes them into two flags: an emphasis flag and an audio/non-audio flag. Bit 0 of the byte selects which emphasis pattern applies, the professional one or the consumer one. Right-channel status never reaches the flags. No CRC is checked.

Top module: `csu_demux`

## Requirements
- R1: While `rstN` is low, every output is low.
- R2: The cycle after a strobe (`subValid` high for one cycle), `csOut` equals that strobe's `subCs`, `userOut` equals its `subUser`, and `chanOut` equals its `subLeft` (1 = left, 0 = right).
- R3: Without a strobe, `csOut`, `userOut` and `chanOut` keep their values, whatever `subCs` and `subUser` carry.
- R4: A strobe with `subLeft` = 1 and `subBlock` = 1 starts a block: that subframe is frame 0, and `blockOut` is high the cycle after.
- R5: `blockOut` stays high through frames 0 to 31 and goes low the cycle after the left strobe of frame 32. Frame numbers count left strobes since the block start.
- R6: A new block start while `blockOut` is high restarts the frame count, so the pulse lasts 32 frames from the newest start.
- R7: Bit k (k = 0..7) of status byte 0 is the `subCs` of the left strobe of frame k. The flags update the cycle after the left strobe of frame 7 and hold until frame 7 of the next block.
- R8: If byte bit 0 = 1 (professional), `emphFlag` = 1 exactly when bit 2 = 1, bit 3 = 1 and bit 4 = 0.
- R9: If byte bit 0 = 0 (consumer), `emphFlag` = 1 exactly when bit 3 = 1, bit 4 = 0 and bit 5 = 0.
- R10: `nonAudioFlag` equals byte bit 1 (0 = PCM audio, 1 = non-audio data).
- R11: The channel-status bits of right subframes have no effect on `emphFlag` or `nonAudioFlag`.
- R12: Until the first block start after reset, the flags stay low and `blockOut` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| subValid | input | 1 | One-cycle strobe per decoded subframe |
| subLeft | input | 1 | Subframe is the left channel |
| subBlock | input | 1 | Subframe carried the block-start preamble (left only) |
| subCs | input | 1 | Channel-status bit of the subframe |
| subUser | input | 1 | User bit of the subframe |
| csOut | output | 1 | Serial channel-status bit |
| userOut | output | 1 | Serial user bit |
| chanOut | output | 1 | Channel of the bit on the serial outputs (1 = left) |
| blockOut | output | 1 | Block-start pulse, 32 frames wide |
| emphFlag | output | 1 | Emphasis indicated in left status byte 0 |
| nonAudioFlag | output | 1 | Left status byte 0 marks non-audio data |

## Verification
Two events can share a cycle: the pulse-restart of a fresh block start, and the flag update at frame 7. A short block of 20 frames is cut off by a new start, so one left strobe both restarts the frame count and begins collecting a new byte 0. The bench then checks that `blockOut` holds for 32 frames from the newest start. It also checks that the flags change at that block's own frame 7, and not at a frame counted from the abandoned block. The bench keeps its own frame count and byte model and compares all six outputs after every strobe and after every idle cycle.

// File: rtl/csu_pkg.sv
package csu_pkg;
  localparam int STATUS_BITS = 8;
  localparam int SEL_W = $clog2(STATUS_BITS);

  typedef struct packed {
    logic             loadSerial;
    logic             captureBit;
    logic [SEL_W-1:0] bitSel;
    logic             updateFlags;
    logic             blockSet;
    logic             blockClr;
  } csuStrobe_t;
endpackage

// File: rtl/csu_ctrl.sv
module csu_ctrl
  import csu_pkg::*;
#(
  parameter int FRAMES_PER_BLOCK = 192,
  parameter int PULSE_FRAMES = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       subValid,
  input  logic       subLeft,
  input  logic       subBlock,
  output csuStrobe_t strobe
);
  localparam int CNT_W = $clog2(FRAMES_PER_BLOCK + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] frameIdx;
  logic [CNT_W-1:0] curIdx;
  logic             synced;
  logic             leftStrobe;
  logic             startStrobe;
  logic             counting;

  always_comb begin
    leftStrobe  = subValid && subLeft;
    startStrobe = leftStrobe && subBlock;
    counting    = leftStrobe && (startStrobe || synced);
    if (startStrobe)
      curIdx = '0;
    else if (frameIdx == CNT_MAX)
      curIdx = frameIdx;
    else
      curIdx = frameIdx + 1'b1;

    strobe             = '0;
    strobe.loadSerial  = subValid;
    strobe.captureBit  = counting && (curIdx < CNT_W'(STATUS_BITS));
    strobe.bitSel      = curIdx[SEL_W-1:0];
    strobe.updateFlags = counting && (curIdx == CNT_W'(STATUS_BITS - 1));
    strobe.blockSet    = startStrobe;
    strobe.blockClr    = counting && !startStrobe && (curIdx == CNT_W'(PULSE_FRAMES));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameIdx <= '0;
      synced   <= 1'b0;
    end else begin
      if (counting) frameIdx <= curIdx;
      if (startStrobe) synced <= 1'b1;
    end
  end
endmodule

// File: rtl/csu_datapath.sv
module csu_datapath
  import csu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  csuStrobe_t strobe,
  input  logic       subLeft,
  input  logic       subCs,
  input  logic       subUser,
  output logic       csOut,
  output logic       userOut,
  output logic       chanOut,
  output logic       blockOut,
  output logic       emphFlag,
  output logic       nonAudioFlag
);
  logic [STATUS_BITS-1:0] byteReg;
  logic [STATUS_BITS-1:0] fullByte;
  logic                   emphNext;

  always_comb begin
    fullByte = {subCs, byteReg[STATUS_BITS-2:0]};
    if (fullByte[0])
      emphNext = fullByte[2] && fullByte[3] && !fullByte[4];
    else
      emphNext = fullByte[3] && !fullByte[4] && !fullByte[5];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csOut        <= 1'b0;
      userOut      <= 1'b0;
      chanOut      <= 1'b0;
      blockOut     <= 1'b0;
      emphFlag     <= 1'b0;
      nonAudioFlag <= 1'b0;
      byteReg      <= '0;
    end else begin
      if (strobe.loadSerial) begin
        csOut   <= subCs;
        userOut <= subUser;
        chanOut <= subLeft;
      end
      if (strobe.captureBit) byteReg[strobe.bitSel] <= subCs;
      if (strobe.updateFlags) begin
        emphFlag     <= emphNext;
        nonAudioFlag <= fullByte[1];
      end
      if (strobe.blockSet)
        blockOut <= 1'b1;
      else if (strobe.blockClr)
        blockOut <= 1'b0;
    end
  end
endmodule

// File: rtl/csu_demux.sv
module csu_demux #(
  parameter int FRAMES_PER_BLOCK = 192,
  parameter int PULSE_FRAMES = 32
) (
  input  logic clk,
  input  logic rstN,
  input  logic subValid,
  input  logic subLeft,
  input  logic subBlock,
  input  logic subCs,
  input  logic subUser,
  output logic csOut,
  output logic userOut,
  output logic chanOut,
  output logic blockOut,
  output logic emphFlag,
  output logic nonAudioFlag
);
  csu_pkg::csuStrobe_t strobe;

  csu_ctrl #(
    .FRAMES_PER_BLOCK(FRAMES_PER_BLOCK),
    .PULSE_FRAMES(PULSE_FRAMES)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .subValid(subValid), .subLeft(subLeft),
    .subBlock(subBlock), .strobe(strobe)
  );

  csu_datapath i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .subLeft(subLeft),
    .subCs(subCs), .subUser(subUser), .csOut(csOut), .userOut(userOut),
    .chanOut(chanOut), .blockOut(blockOut), .emphFlag(emphFlag),
    .nonAudioFlag(nonAudioFlag)
  );
endmodule

// File: rtl/csu_demux_chk.sv
module csu_demux_chk (
  input logic clk,
  input logic rstN,
  input logic subValid,
  input logic subLeft,
  input logic subBlock,
  input logic subCs,
  input logic subUser,
  input logic csOut,
  input logic userOut,
  input logic chanOut,
  input logic blockOut,
  input logic emphFlag,
  input logic nonAudioFlag
);
  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else armed <= 1'b1;
  end

  always_comb begin
    if (!rstN) begin
      assert_reset_low_R1: assert (!csOut && !userOut && !chanOut && !blockOut
                                   && !emphFlag && !nonAudioFlag);
    end
  end

  assert_serial_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    subValid |=> (csOut == $past(subCs)) && (userOut == $past(subUser))
                 && (chanOut == $past(subLeft)));

  assert_serial_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !subValid |=> $stable(csOut) && $stable(userOut) && $stable(chanOut));

  assert_block_start_R4: assert property (@(posedge clk) disable iff (!rstN)
    (subValid && subLeft && subBlock) |=> blockOut);

  assert_block_rise_R5: assert property (@(posedge clk) disable iff (!rstN || !armed)
    $rose(blockOut) |-> $past(subValid && subLeft && subBlock));

  assert_flags_left_only_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(subValid && subLeft) |=> $stable(emphFlag) && $stable(nonAudioFlag));
endmodule

bind csu_demux csu_demux_chk i_chk (.*);

// File: tb/test_csu_demux.sv
module test_csu_demux;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic subValid = 1'b0, subLeft = 1'b0, subBlock = 1'b0, subCs = 1'b0, subUser = 1'b0;
  logic csOut, userOut, chanOut, blockOut, emphFlag, nonAudioFlag;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // bench model state
  int  mIdx = 0;
  bit  mSynced = 1'b0;
  bit [7:0] mByte = '0;
  bit  mCs = 0, mUser = 0, mChan = 0, mBlk = 0, mEmph = 0, mNon = 0;

  always #2 clk = ~clk;

  csu_demux i_csu_demux (
    .clk(clk), .rstN(rstN), .subValid(subValid), .subLeft(subLeft),
    .subBlock(subBlock), .subCs(subCs), .subUser(subUser), .csOut(csOut),
    .userOut(userOut), .chanOut(chanOut), .blockOut(blockOut),
    .emphFlag(emphFlag), .nonAudioFlag(nonAudioFlag)
  );

  function automatic bit expEmph(bit [7:0] b);
    if (b[0]) return b[2] && b[3] && !b[4];   // professional pattern
    return b[3] && !b[4] && !b[5];            // consumer pattern
  endfunction

  task automatic chk(string tag, logic got, bit exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic chkAll(string tag);
    chk({tag, " csOut R2"}, csOut, mCs);
    chk({tag, " userOut R2"}, userOut, mUser);
    chk({tag, " chanOut R2"}, chanOut, mChan);
    chk({tag, " blockOut R5"}, blockOut, mBlk);
    chk({tag, " emphFlag R7"}, emphFlag, mEmph);
    chk({tag, " nonAudioFlag R7"}, nonAudioFlag, mNon);
  endtask

  task automatic sendSub(bit left, bit blk, bit cs, bit usr);
    @(negedge clk);
    subValid = 1'b1; subLeft = left; subBlock = blk; subCs = cs; subUser = usr;
    mCs = cs; mUser = usr; mChan = left;
    if (left) begin
      if (blk) begin
        mIdx = 0; mSynced = 1'b1; mBlk = 1'b1;
      end else if (mSynced) begin
        if (mIdx < 255) mIdx++;
        if (mIdx == 32) mBlk = 1'b0;
      end
      if (mSynced && mIdx < 8) begin
        mByte[mIdx] = cs;
        if (mIdx == 7) begin
          mEmph = expEmph(mByte);
          mNon = mByte[1];
        end
      end
    end
    @(negedge clk);
    subValid = 1'b0; subBlock = $urandom_range(0, 1);
    subLeft = $urandom_range(0, 1);
    chkAll("strobe");
    // idle cycle with junk on the data inputs: outputs must hold (R3)
    subCs = $urandom_range(0, 1); subUser = $urandom_range(0, 1);
    @(negedge clk);
    chkAll("idle R3");
  endtask

  // rightMode: 0 random right status, 1 right status all ones
  task automatic runBlock(bit [7:0] byte0, int nFrames, bit withStart, bit rightMode);
    for (int f = 0; f < nFrames; f++) begin
      bit lcs;
      lcs = (f < 8) ? byte0[f] : 1'($urandom_range(0, 1));
      sendSub(1'b1, withStart && f == 0, lcs, 1'($urandom_range(0, 1)));
      sendSub(1'b0, 1'b0, rightMode ? 1'b1 : 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1703));
    subCs = 1'b1; subUser = 1'b1;
    repeat (3) @(negedge clk);
    chk("reset csOut R1", csOut, 1'b0);
    chk("reset blockOut R1", blockOut, 1'b0);
    chk("reset flags R1", emphFlag | nonAudioFlag, 1'b0);
    subCs = 1'b0; subUser = 1'b0;
    @(negedge clk); rstN = 1'b1;

    // R12: no start yet, left status bits look like a flagged byte
    runBlock(8'hFF, 12, 1'b0, 1'b0);
    chk("unsynced emph R12", emphFlag, 1'b0);
    chk("unsynced nonAudio R12", nonAudioFlag, 1'b0);
    chk("unsynced block R12", blockOut, 1'b0);

    runBlock(8'h0D, 192, 1'b1, 1'b0);
    chk("pro emphasis on R8", emphFlag, 1'b1);
    runBlock(8'h1D, 192, 1'b1, 1'b0);
    chk("pro bit4 set R8", emphFlag, 1'b0);
    runBlock(8'h08, 192, 1'b1, 1'b0);
    chk("consumer emphasis on R9", emphFlag, 1'b1);
    runBlock(8'h28, 192, 1'b1, 1'b0);
    chk("consumer bit5 set R9", emphFlag, 1'b0);
    runBlock(8'h02, 192, 1'b1, 1'b0);
    chk("non-audio R10", nonAudioFlag, 1'b1);
    runBlock(8'h00, 192, 1'b1, 1'b1);
    chk("right status ignored emph R11", emphFlag, 1'b0);
    chk("right status ignored nonAudio R11", nonAudioFlag, 1'b0);

    // R4 and R6: truncated block, then a fresh start while the pulse is high
    runBlock(8'h0C, 20, 1'b1, 1'b0);
    chk("short block pulse high R4", blockOut, 1'b1);
    runBlock(8'h0D, 31, 1'b1, 1'b0);
    chk("restart pulse still high R6", blockOut, 1'b1);
    runBlock(8'h00, 2, 1'b0, 1'b0);
    chk("restart pulse low at frame 32 R6", blockOut, 1'b0);

    for (int i = 0; i < 6; i++)
      runBlock(8'($urandom_range(0, 255)), 192, 1'b1, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule